// File: doc/BRIEF.md
# Float64 to Integer Modulo Converter

This block turns an IEEE-754 double-precision operand into a signed integer of `OUT_W` bits (normally 32 or 64) without saturating. The operand is rounded to an integer in one of four rounding directions, and the output carries the low `OUT_W` bits of that integer's two's-complement form, even when the integer does not fit. A second, wider flag set describes the conversion: inexact, invalid, integer overflow, signalling-NaN and a combined "not exact" indication.

One request is accepted per clock through a valid strobe. The converted value and its flags appear one cycle later under an output valid strobe. They hold their previous values whenever no request arrives. Typical uses are emulating processor convert-to-integer instructions that produce wrapped results, and script-engine style 32-bit truncation.

Top module: `f64_to_int_modulo`

## Requirements
- R1: A request presented with `inValid` high on one rising edge appears on the outputs with `outValid` high after that edge. `outValid` is low in the cycle after an edge without a request. After reset all outputs read zero. The result and flag outputs keep their last values while no request arrives.
- R2: The operand bit 63 is the sign, bits 62:52 the biased exponent (bias 1023) and bits 51:0 the fraction. `inRoundMode` selects 0 = toward zero, 1 = toward minus infinity, 2 = nearest with ties to even, 3 = toward plus infinity. An in-range finite operand yields its rounded integer.
- R3: An operand with exponent all ones and a nonzero fraction (NaN) yields result 0 with invalid set. `outSnan` is also set when fraction bit 51 is clear.
- R4: An infinity (exponent all ones, fraction zero) yields result 0 with invalid set and overflow and inexact clear.
- R5: A zero of either sign yields result 0 with inexact, invalid, overflow and signalling-NaN all clear.
- R6: Inexact is set for a finite nonzero operand whenever the rounding discards nonzero fraction bits, or when an overflow occurs.
- R7: A subnormal operand (exponent 0, nonzero fraction) yields 0. In a directed mode that rounds it away from zero, it yields +1 or -1 instead. Inexact is always set.
- R8: A finite operand whose rounded integer lies outside [-2^(OUT_W-1), 2^(OUT_W-1)-1] sets overflow and inexact and leaves invalid clear. Exactly -2^(OUT_W-1) raises no flag.
- R9: On overflow the result is the low `OUT_W` bits of the two's complement of the rounded integer. For example, 2^64 gives 0 and 0x1.ccc·2^64 gives 0xccc0000000000000 at 64 bits.
- R10: `outNotExact` is the OR of inexact, invalid and "operand is negative zero".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request strobe |
| inOperand | input | 64 | Double-precision operand |
| inRoundMode | input | 2 | Rounding direction code |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outResult | output | OUT_W | Wrapped two's-complement integer |
| outInexact | output | 1 | Fraction bits discarded or overflow |
| outInvalid | output | 1 | NaN or infinity operand |
| outOverflow | output | 1 | Finite operand outside the integer range |
| outSnan | output | 1 | Operand was a signalling NaN |
| outNotExact | output | 1 | Inexact, invalid or negative zero |

## Verification
The bench builds two instances side by side, one with `OUT_W` = 64 and one with `OUT_W` = 32, and feeds both the same operands. The 64-bit build reaches the listed wrap vectors and the -2^63 boundary. The 32-bit build reaches the -2^31 boundary, rounding that carries a value just under 2^31 into overflow, and the negative-zero "not exact" case. Directed operands run through all four rounding modes, and random operands concentrated around both integer ranges cover the remaining shift distances.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int F64W   = 64;
  localparam int EXPW   = 11;
  localparam int FRACW  = 52;
  localparam int BIAS   = 1023;
  localparam int SIGW   = FRACW + 1;

  typedef enum logic [1:0] {
    RND_ZERO = 2'd0,
    RND_DOWN = 2'd1,
    RND_NEAR = 2'd2,
    RND_UP   = 2'd3
  } rndMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic isNan;
    logic isSnan;
    logic isInf;
    logic isZero;
    logic isSub;
  } convStrobe_t;

endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [EXPW-1:0]   opExp,
  input  logic [FRACW-1:0]  opFrac,
  output convStrobe_t       strobes,
  output logic              outValid
);

  logic expAllOnes;
  logic expAllZero;
  logic fracNonZero;

  always_comb begin
    expAllOnes     = &opExp;
    expAllZero     = ~|opExp;
    fracNonZero    = |opFrac;
    strobes.loadEn = inValid;
    strobes.isNan  = expAllOnes & fracNonZero;
    strobes.isSnan = expAllOnes & fracNonZero & ~opFrac[FRACW-1];
    strobes.isInf  = expAllOnes & ~fracNonZero;
    strobes.isZero = expAllZero & ~fracNonZero;
    strobes.isSub  = expAllZero & fracNonZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int OUT_W = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [F64W-1:0]   operand,
  input  logic [1:0]        roundMode,
  input  convStrobe_t       strobes,
  output logic [OUT_W-1:0]  outResult,
  output logic              outInexact,
  output logic              outInvalid,
  output logic              outOverflow,
  output logic              outSnan,
  output logic              outNotExact
);

  localparam logic [63:0]        MIN_MAG  = 64'd1 << (OUT_W - 1);
  localparam logic signed [12:0] TOP_EXP  = 13'(OUT_W - 1);
  localparam int                 WIN_W    = SIGW + 64;

  logic                 opSign;
  logic [EXPW-1:0]      expField;
  logic [FRACW-1:0]     fracField;
  logic [SIGW-1:0]      sig;
  logic signed [12:0]   unbExp;
  logic signed [12:0]   shlS;
  logic signed [12:0]   rshS;
  logic                 leftCase;
  logic [63:0]          leftMag;
  logic [WIN_W-1:0]     window;
  logic [SIGW-1:0]      intPart;
  logic                 guardBit;
  logic                 stickyBit;
  logic                 roundUp;
  logic [63:0]          rightMag;
  logic [63:0]          mag;
  logic [63:0]          signedVal;
  logic                 ovf;
  logic                 lostBits;

  logic [OUT_W-1:0]     nxtResult;
  logic                 nxtInexact;
  logic                 nxtInvalid;
  logic                 nxtOverflow;
  logic                 nxtSnan;
  logic                 nxtNotExact;

  // unpack and align
  always_comb begin
    opSign    = operand[F64W-1];
    expField  = operand[F64W-2 -: EXPW];
    fracField = operand[FRACW-1:0];
    sig       = {~strobes.isSub, fracField};
    unbExp    = strobes.isSub ? -13'sd1022
                              : ($signed({2'b00, expField}) - 13'sd1023);
    shlS      = unbExp - 13'sd52;
    rshS      = 13'sd52 - unbExp;
    leftCase  = (shlS >= 13'sd0);
  end

  // large operands: exact, shift left and keep low bits
  always_comb begin
    if (shlS >= 13'sd64) leftMag = '0;
    else                 leftMag = 64'(sig) << shlS[5:0];
  end

  // small operands: shift right, keep guard and sticky
  always_comb begin
    window = '0;
    if (!leftCase && rshS <= 13'sd64) begin
      window    = {sig, 64'b0} >> rshS[6:0];
      intPart   = window[WIN_W-1 -: SIGW];
      guardBit  = window[63];
      stickyBit = |window[62:0];
    end else begin
      intPart   = '0;
      guardBit  = 1'b0;
      stickyBit = |sig;
    end
  end

  // rounding increment per direction
  always_comb begin
    unique case (rndMode_e'(roundMode))
      RND_ZERO: roundUp = 1'b0;
      RND_DOWN: roundUp = opSign & (guardBit | stickyBit);
      RND_NEAR: roundUp = guardBit & (stickyBit | intPart[0]);
      RND_UP:   roundUp = ~opSign & (guardBit | stickyBit);
      default:  roundUp = 1'b0;
    endcase
    rightMag = 64'(intPart) + 64'(roundUp);
  end

  // range check, wrap and sign
  always_comb begin
    if (leftCase) begin
      ovf      = (unbExp > TOP_EXP) ||
                 (unbExp == TOP_EXP && !(opSign && fracField == '0));
      mag      = leftMag;
      lostBits = 1'b0;
    end else begin
      ovf      = opSign ? (rightMag > MIN_MAG) : (rightMag >= MIN_MAG);
      mag      = rightMag;
      lostBits = guardBit | stickyBit;
    end
    signedVal = opSign ? (64'd0 - mag) : mag;
  end

  // select by operand class
  always_comb begin
    nxtResult   = '0;
    nxtInexact  = 1'b0;
    nxtInvalid  = 1'b0;
    nxtOverflow = 1'b0;
    nxtSnan     = 1'b0;
    if (strobes.isNan) begin
      nxtInvalid = 1'b1;
      nxtSnan    = strobes.isSnan;
    end else if (strobes.isInf) begin
      nxtInvalid = 1'b1;
    end else if (!strobes.isZero) begin
      nxtResult   = signedVal[OUT_W-1:0];
      nxtOverflow = ovf;
      nxtInexact  = lostBits | ovf;
    end
    nxtNotExact = nxtInexact | nxtInvalid | (strobes.isZero & opSign);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult   <= '0;
      outInexact  <= 1'b0;
      outInvalid  <= 1'b0;
      outOverflow <= 1'b0;
      outSnan     <= 1'b0;
      outNotExact <= 1'b0;
    end else if (strobes.loadEn) begin
      outResult   <= nxtResult;
      outInexact  <= nxtInexact;
      outInvalid  <= nxtInvalid;
      outOverflow <= nxtOverflow;
      outSnan     <= nxtSnan;
      outNotExact <= nxtNotExact;
    end
  end

  // R3
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn && strobes.isNan |=> outInvalid && outResult == '0);

  // R4
  inf_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn && strobes.isInf |=> outInvalid && !outOverflow && !outInexact);

  // R5
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn && strobes.isZero |=> outResult == '0 && !outInexact && !outInvalid);

  // R8
  ovf_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    outOverflow |-> outInexact && !outInvalid);

  // R3
  snan_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSnan |-> outInvalid);

  // R10
  not_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outInexact || outInvalid) |-> outNotExact);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(outResult) && $stable(outNotExact));

endmodule

// File: rtl/f64_to_int_modulo.sv
module f64_to_int_modulo
  import f2i_pkg::*;
#(
  parameter int OUT_W = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [63:0]       inOperand,
  input  logic [1:0]        inRoundMode,
  output logic              outValid,
  output logic [OUT_W-1:0]  outResult,
  output logic              outInexact,
  output logic              outInvalid,
  output logic              outOverflow,
  output logic              outSnan,
  output logic              outNotExact
);

  convStrobe_t strobes;

  f2i_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opExp    (inOperand[62:52]),
    .opFrac   (inOperand[51:0]),
    .strobes  (strobes),
    .outValid (outValid)
  );

  f2i_datapath #(.OUT_W(OUT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .operand     (inOperand),
    .roundMode   (inRoundMode),
    .strobes     (strobes),
    .outResult   (outResult),
    .outInexact  (outInexact),
    .outInvalid  (outInvalid),
    .outOverflow (outOverflow),
    .outSnan     (outSnan),
    .outNotExact (outNotExact)
  );

endmodule

// File: tb/f64_to_int_modulo_tb.sv
module f64_to_int_modulo_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        inx;
    logic        inv;
    logic        ovf;
    logic        snan;
    logic        nex;
    string       resTag;
    string       invTag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inOperand = '0;
  logic [1:0]  inRoundMode = '0;

  logic        v64, inx64, inv64, ovf64, sn64, nex64;
  logic [63:0] res64;
  logic        v32, inx32, inv32, ovf32, sn32, nex32;
  logic [31:0] res32;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f64_to_int_modulo #(.OUT_W(64)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .inRoundMode(inRoundMode), .outValid(v64), .outResult(res64),
    .outInexact(inx64), .outInvalid(inv64), .outOverflow(ovf64),
    .outSnan(sn64), .outNotExact(nex64));

  f64_to_int_modulo #(.OUT_W(32)) u_dut32 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .inRoundMode(inRoundMode), .outValid(v32), .outResult(res32),
    .outInexact(inx32), .outInvalid(inv32), .outOverflow(ovf32),
    .outSnan(sn32), .outNotExact(nex32));

  // behavioural reference: 256-bit fixed point with 128 fraction bits
  function automatic exp_t model(logic [63:0] op, logic [1:0] rm, int n);
    exp_t e;
    logic        s;
    int          ex, ue, p;
    logic [52:0] sg;
    logic [255:0] fx;
    logic [127:0] ip, fr, half, mg, lim, sv;
    logic below, frZero, up;
    s  = op[63];
    ex = int'(op[62:52]);
    e.res = '0; e.inx = 0; e.inv = 0; e.ovf = 0; e.snan = 0;
    e.resTag = "R2"; e.invTag = "R8";
    if (ex == 2047) begin
      e.inv = 1;
      if (op[51:0] != 0) begin
        e.snan = ~op[51]; e.resTag = "R3"; e.invTag = "R3";
      end else begin
        e.resTag = "R4"; e.invTag = "R4";
      end
    end else if (ex == 0 && op[51:0] == 0) begin
      e.resTag = "R5";
    end else begin
      sg = (ex == 0) ? {1'b0, op[51:0]} : {1'b1, op[51:0]};
      ue = (ex == 0) ? -1022 : ex - 1023;
      if (ex == 0) e.resTag = "R7";
      if (ue >= 120) begin
        e.ovf = 1; e.inx = 1; e.res = '0; e.resTag = "R9";
      end else begin
        p = ue - 52 + 128;
        below = 0;
        if (p >= 0) fx = 256'(sg) << p;
        else if (-p > 60) begin fx = '0; below = 1; end
        else begin
          fx = 256'(sg) >> (-p);
          below = ((256'(sg) << (256 + p)) != 0);
        end
        ip = fx[255:128]; fr = fx[127:0];
        half = 128'd1 << 127;
        frZero = (fr == 0) && !below;
        case (rm)
          2'd0: up = 0;
          2'd1: up = s & !frZero;
          2'd2: up = (fr > half) || (fr == half && below) ||
                     (fr == half && !below && ip[0]);
          default: up = !s & !frZero;
        endcase
        mg  = ip + 128'(up);
        lim = 128'd1 << (n - 1);
        e.ovf = s ? (mg > lim) : (mg >= lim);
        e.inx = !frZero | e.ovf;
        sv = s ? (128'd0 - mg) : mg;
        e.res = sv[63:0];
        if (e.ovf) e.resTag = "R9";
      end
    end
    if (n == 32) e.res = {32'b0, e.res[31:0]};
    e.nex = e.inx | e.inv | (s && op[62:0] == 0);
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  logic        pendValid = 0;
  exp_t        pend64, pend32;
  logic [63:0] held64 = '0;
  logic [63:0] held32 = '0;

  task automatic compare_all();
    chk("R1", "valid64", 64'(v64), 64'(pendValid));
    chk("R1", "valid32", 64'(v32), 64'(pendValid));
    if (pendValid) begin
      chk(pend64.resTag, "result64", res64, pend64.res);
      chk("R6", "inexact64", 64'(inx64), 64'(pend64.inx));
      chk(pend64.invTag, "invalid64", 64'(inv64), 64'(pend64.inv));
      chk("R8", "overflow64", 64'(ovf64), 64'(pend64.ovf));
      chk("R3", "snan64", 64'(sn64), 64'(pend64.snan));
      chk("R10", "notexact64", 64'(nex64), 64'(pend64.nex));
      chk(pend32.resTag, "result32", {32'b0, res32}, pend32.res);
      chk("R6", "inexact32", 64'(inx32), 64'(pend32.inx));
      chk(pend32.invTag, "invalid32", 64'(inv32), 64'(pend32.inv));
      chk("R8", "overflow32", 64'(ovf32), 64'(pend32.ovf));
      chk("R3", "snan32", 64'(sn32), 64'(pend32.snan));
      chk("R10", "notexact32", 64'(nex32), 64'(pend32.nex));
      held64 = pend64.res;
      held32 = pend32.res;
    end else begin
      chk("R1", "hold64", res64, held64);
      chk("R1", "hold32", {32'b0, res32}, held32);
    end
  endtask

  task automatic step(logic v, logic [63:0] op, logic [1:0] rm);
    @(negedge clk);
    compare_all();
    inValid = v; inOperand = op; inRoundMode = rm;
    pendValid = v;
    if (v) begin
      pend64 = model(op, rm, 64);
      pend32 = model(op, rm, 32);
    end
  endtask

  localparam int NDIR = 24;
  logic [63:0] dirOps [NDIR] = '{
    64'h3FF0000000000000, 64'hBFF0000000000000, 64'h3FF8000000000000,
    64'h4004000000000000, 64'hC004000000000000, 64'h3FE0000000000000,
    64'h41F0000000000000, 64'hC3E0000000000000, 64'h43E0000000000000,
    64'h43F0000000000000, 64'h43FCCC0000000000, 64'h7FF0000000000000,
    64'hFFF0000000000000, 64'h7FF8000000000000, 64'h7FF0000000000001,
    64'h0000000000000000, 64'h8000000000000000, 64'h0000000000000001,
    64'h8000000000000001, 64'h41E0000000000000, 64'hC1E0000000000000,
    64'h41DFFFFFFFE00000, 64'hC1E0000000100000, 64'h7FEFFFFFFFFFFFFF
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: first compare checks the reset state
    step(0, '0, 2'd0);
    // R2 R3 R4 R5 R7 R8 R9 directed operands in every rounding mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < NDIR; i++) step(1, dirOps[i], 2'(m));
    // R1: idle cycles hold the last result
    step(0, 64'h3FF0000000000000, 2'd0);
    step(0, '0, 2'd0);
    // back-to-back random operands near both integer ranges (R2 R6 R8 R9)
    for (int i = 0; i < 600; i++) begin
      logic [63:0] op;
      logic [10:0] ex;
      op = {$urandom, $urandom};
      ex = 11'(1023 - 4 + ($urandom % 80));
      if (i % 5 != 0) op[62:52] = ex;
      step((i % 7) != 3, op, 2'($urandom));
    end
    step(0, '0, 2'd0);
    step(0, '0, 2'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule